// File: doc/BRIEF.md
# Alarm/Timer Interrupt Flag Controller

This block keeps two event flags, one for an alarm match and one for a countdown timer reaching zero, together with an enable per source and a timer mode bit. It turns them into a request to pull an active-low, open-drain interrupt pin low. The alarm comparator and the countdown timer sit outside the block. Each one reports through a strobe that is high for a single cycle.

Software reaches the block through one control byte, which it can both write and read. A flag can be cleared from software but can never be set from software. In level mode the timer request holds the pin low until software clears the timer flag. In periodic mode the pin is pulled low for a fixed number of cycles and then released, while the flag stays set until software clears it. When a neighbouring frequency output owns the pin, this block lets go of it.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, `rd_data` is 0x00 and `irq_pull` is 0.
- R2: The control byte layout is bit 4 = timer mode (0 level, 1 periodic), bit 3 = alarm flag, bit 2 = timer flag, bit 1 = alarm enable, bit 0 = timer enable. A write stores bits 4, 1 and 0 directly. Bits 7 to 5 always read back as 0.
- R3: The cycle after `alarm_evt` is high, bit 3 reads 1. The cycle after `timer_evt` is high, bit 2 reads 1.
- R4: Writing 0 to a flag bit clears that flag. Writing 1 to a flag bit leaves it unchanged, so a write never sets a flag.
- R5: If an event strobe arrives in the same cycle as a write that would clear its flag, the flag is left set.
- R6: In level mode with the timer enable at 1, `irq_pull` is 1 for as long as the timer flag is 1.
- R7: In periodic mode with the timer enable at 1, `irq_pull` is 1 for exactly PULSE_LEN cycles after a timer event and then goes to 0. The timer flag stays 1 until it is cleared.
- R8: With the alarm enable at 1, `irq_pull` is 1 for as long as the alarm flag is 1, in either mode.
- R9: A set flag whose enable is 0 has no effect on `irq_pull`.
- R10: While `freq_out_active` is 1, `irq_pull` is 0. The flags still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte to write |
| rd_data | output | 8 | Current control byte |
| alarm_evt | input | 1 | Single-cycle alarm match strobe |
| timer_evt | input | 1 | Single-cycle timer-at-zero strobe |
| freq_out_active | input | 1 | The frequency output owns the pin |
| irq_pull | output | 1 | 1 = pull the interrupt pin low; 0 = high impedance |

## Verification
Two things can fall in the same cycle: an event strobe setting a flag, and a software write clearing that same flag. The bench provokes this by raising `alarm_evt` or `timer_evt` in the same cycle as a write of zeros to the flag bits. It then judges the result by reading the flag back as set and by seeing the pin request asserted. The bench also sweeps every combination of mode, both enables, the pin-ownership input and the event source. For each one it follows `irq_pull` cycle by cycle against an arithmetic expectation.

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter int PULSE_LEN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       alarm_evt,
  input  logic       timer_evt,
  input  logic       freq_out_active,
  output logic       irq_pull
);
  localparam int CW = $clog2(PULSE_LEN + 1);

  logic          periodic, aflag, tflag, a_en, t_en;
  logic [CW-1:0] pulse_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      periodic <= 1'b0;
      a_en     <= 1'b0;
      t_en     <= 1'b0;
    end else if (wr_en) begin
      periodic <= wr_data[4];
      a_en     <= wr_data[1];
      t_en     <= wr_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aflag <= 1'b0;
      tflag <= 1'b0;
    end else begin
      if (alarm_evt)                 aflag <= 1'b1;
      else if (wr_en && !wr_data[3]) aflag <= 1'b0;
      if (timer_evt)                 tflag <= 1'b1;
      else if (wr_en && !wr_data[2]) tflag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             pulse_cnt <= '0;
    else if (timer_evt && periodic && t_en) pulse_cnt <= CW'(PULSE_LEN);
    else if (pulse_cnt != '0)               pulse_cnt <= pulse_cnt - 1'b1;
  end

  wire alarm_req = aflag && a_en;
  wire level_req = tflag && t_en && !periodic;
  wire pulse_req = (pulse_cnt != '0) && t_en && periodic;

  assign irq_pull = !freq_out_active && (alarm_req || level_req || pulse_req);
  assign rd_data  = {3'b000, periodic, aflag, tflag, a_en, t_en};
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       alarm_evt,
  input logic       timer_evt,
  input logic       freq_out_active,
  input logic       irq_pull
);
  p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:5] == 3'b000);
  p_alarm_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |=> rd_data[3]);
  p_timer_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    timer_evt |=> rd_data[2]);
  p_no_sw_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_evt && !rd_data[3]) |=> !rd_data[3]);
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[2] && !timer_evt) |=> !rd_data[2]);
  p_evt_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[3] && alarm_evt) |=> rd_data[3]);
  p_level_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[2] && rd_data[0] && !rd_data[4] && !freq_out_active) |-> irq_pull);
  p_alarm_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3] && rd_data[1] && !freq_out_active) |-> irq_pull);
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1:0] == 2'b00) |-> !irq_pull);
  p_freq_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    freq_out_active |-> !irq_pull);
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk chk_i (.*);

// File: tb/irq_flag_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_flag_ctrl_tb_top;
  localparam int P = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, alarm_evt = 1'b0, timer_evt = 1'b0, freq_out_active = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic irq_pull;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_flag_ctrl #(.PULSE_LEN(P)) dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [7:0] wd, input logic ae, input logic te);
    wr_en = we; wr_data = wd; alarm_evt = ae; timer_evt = te;
    @(posedge clk); #1;
    wr_en = 1'b0; alarm_evt = 1'b0; timer_evt = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rd_data", rd_data, 0);
    chk("R1 irq_pull", irq_pull, 0);
    rst_n = 1'b1;
    cyc(1'b0, 8'h00, 1'b0, 1'b0);

    // R2/R4: every byte written with flags clear; flags cannot be set by writing
    for (int d = 0; d < 256; d++) begin
      cyc(1'b1, d[7:0], 1'b0, 1'b0);
      chk("R2 R4 readback", rd_data, (d & 8'h13));
    end

    // R3 R6 R7 R8 R9 R10: sweep mode, enables, pin ownership, event source
    for (int cfg = 0; cfg < 8; cfg++) begin
      for (int fq = 0; fq < 2; fq++) begin
        for (int ev = 1; ev < 4; ev++) begin
          int md, ae, te;
          logic [7:0] base;
          md = (cfg >> 2) & 1; ae = (cfg >> 1) & 1; te = cfg & 1;
          base = 8'((md << 4) | (ae << 1) | te);
          freq_out_active = fq[0];
          cyc(1'b1, base, 1'b0, 1'b0);
          cyc(1'b0, 8'h00, ev[0], ev[1]);
          chk("R3 flags", rd_data, base | ((ev & 1) << 3) | ((ev >> 1) << 2));
          for (int k = 1; k <= P + 3; k++) begin
            int exp;
            exp = 0;
            if (ev[0] && ae == 1) exp = 1;
            if (ev[1] && te == 1 && (md == 0 || k <= P)) exp = 1;
            if (fq == 1) exp = 0;
            chk("R6 R7 R8 R9 R10 irq", irq_pull, exp);
            if (k < P + 3) cyc(1'b0, 8'h00, 1'b0, 1'b0);
          end
          chk("R7 flag held", rd_data, base | ((ev & 1) << 3) | ((ev >> 1) << 2));
          cyc(1'b1, base, 1'b0, 1'b0);
          chk("R4 cleared", rd_data, base);
          chk("R4 released", irq_pull, 0);
        end
      end
    end
    freq_out_active = 1'b0;

    // R4: writing 1 to a set flag keeps it; clearing one flag leaves the other
    cyc(1'b1, 8'h03, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 1'b1, 1'b1);
    cyc(1'b1, 8'h0F, 1'b0, 1'b0);
    chk("R4 write one keeps", rd_data, 8'h0F);
    cyc(1'b1, 8'h0B, 1'b0, 1'b0);
    chk("R4 selective clear", rd_data, 8'h0B);
    cyc(1'b1, 8'h03, 1'b0, 1'b0);

    // R5: strobe and clearing write in the same cycle
    cyc(1'b1, 8'h03, 1'b0, 1'b1);
    chk("R5 timer wins", rd_data, 8'h07);
    chk("R5 level pull", irq_pull, 1);
    cyc(1'b1, 8'h03, 1'b1, 1'b0);
    chk("R5 alarm wins", rd_data, 8'h0B);
    cyc(1'b1, 8'h03, 1'b0, 1'b0);
    chk("R5 cleared after", rd_data, 8'h03);

    // R7: a new timer event restarts the pulse
    cyc(1'b1, 8'h11, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    repeat (P - 2) cyc(1'b0, 8'h00, 1'b0, 0);
    cyc(1'b0, 8'h00, 1'b0, 1'b1);
    for (int k = 1; k <= P + 1; k++) begin
      chk("R7 restart", irq_pull, (k <= P) ? 1 : 0);
      cyc(1'b0, 8'h00, 1'b0, 1'b0);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule